// File: doc/BRIEF.md
# Multi-lane link packet receiver

This block sits behind the lane deskew logic of a serial link and turns the byte-striped receive stream back into packets. Every cycle it takes `LANES` bytes, lane 0 carrying the earliest byte. A packet always starts on lane 0 of a valid cycle. The first four bytes form the header: a data identifier, a 16-bit word count and an error-correcting code byte. The header is checked, a single-bit error is repaired, and the header fields are presented to the application.

Packets whose identifier is above a threshold are long packets. They carry `word count` payload bytes and then a two-byte CRC. The block marks the payload lanes with per-lane strobes and runs the CRC across the lanes in the same cycle. It compares that CRC with the received one and marks the end of the packet together with the result. Filler bytes that close out the final cycle are ignored. Header and CRC errors are reported as flags. Each error class can separately be allowed to raise a one-cycle request for a link reset toward the training state machine.

Top module: `slrx_packet_rx`

## Requirements
- R1: While `rst_n` is low, `hdr_valid`, `hdr_long`, `pl_strb`, `pl_eop`, `pl_crc_err`, `err_ecc_corr`, `err_ecc_fatal`, `link_reset_req`, `hdr_di`, `hdr_wc` and `pl_data` are all zero.
- R2: When the block is idle, a cycle with `rx_valid` high is a header cycle. Lane 0 is the identifier, lane 1 is the low byte of the word count, lane 2 is its high byte and lane 3 is the check byte. One cycle later `hdr_valid` pulses with `hdr_di` and `hdr_wc` set.
- R3: The check byte's bits 5:0 are a SEC-DED code over the 24 header bits `{wc, di}`. Data bit j sits at the j-th code position counting upward from 3 and skipping powers of two. Bits 4:0 are the XOR of the positions of all set data bits. Bit 5 makes the parity of the 24 data bits and the six code bits even. Check-byte bits 7:6 are ignored. A clean header raises no error flag.
- R4: A header with exactly one flipped bit among its 30 coded bits is repaired. `hdr_valid` carries the corrected fields, `err_ecc_corr` pulses in the same cycle, and a long packet is then parsed with the corrected word count.
- R5: A header with two flipped coded bits makes `err_ecc_fatal` pulse one cycle later. No `hdr_valid` appears, no payload strobe appears, and the next valid cycle is taken as a new header.
- R6: A header whose corrected identifier is greater than 0x0F starts a long packet and sets `hdr_long`. The payload bytes follow the header at stream positions 4 to 3+wc, with stream position c*LANES+lane. One cycle after each input cycle, `pl_strb` has a bit set for each payload lane and `pl_data` holds that cycle's lane bytes.
- R7: The CRC starts at 0xFFFF and uses the reflected polynomial 0x8408, taking each byte LSB first, with no final inversion. It covers the payload only. It is received low byte first, directly after the payload. `pl_eop` pulses one cycle after the input cycle that holds the CRC high byte, and `pl_crc_err` is high together with it exactly when the received and computed values differ.
- R8: Bytes after the CRC high byte in its cycle are ignored whatever their value: they are never strobed and never affect the CRC result.
- R9: A cycle with `rx_valid` low inside a long packet is skipped. One cycle later no strobe, `hdr_valid` or `pl_eop` is present, and parsing resumes unchanged on the next valid cycle.
- R10: `link_reset_req` pulses in the same cycle as `err_ecc_fatal` when `cfg_rst_on_fatal` is set, as `err_ecc_corr` when `cfg_rst_on_corr` is set, and as `pl_crc_err` when `cfg_rst_on_crc` is set.
- R11: With the matching enable clear, none of those error events raises `link_reset_req`.
- R12: A header with identifier up to 0x0F is a short packet. It produces no strobe and no `pl_eop`, and a new header may arrive in the very next cycle.
- R13: A long packet with word count 0 gives `pl_eop` with no strobe. Its received CRC is checked against the seed value 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Lane bytes valid this cycle |
| rx_data | input | LANES*8 | Deskewed lane bytes, lane 0 in bits 7:0 |
| cfg_rst_on_fatal | input | 1 | Allow reset request on uncorrectable header |
| cfg_rst_on_corr | input | 1 | Allow reset request on corrected header |
| cfg_rst_on_crc | input | 1 | Allow reset request on payload CRC mismatch |
| hdr_valid | output | 1 | Header accepted pulse |
| hdr_di | output | 8 | Corrected data identifier |
| hdr_wc | output | 16 | Corrected word count |
| hdr_long | output | 1 | Accepted header starts a long packet |
| pl_data | output | LANES*8 | Lane bytes of the previous input cycle |
| pl_strb | output | LANES | Lanes of `pl_data` that hold payload |
| pl_eop | output | 1 | Long packet ended (CRC checked) |
| pl_crc_err | output | 1 | CRC mismatch, only with `pl_eop` |
| err_ecc_corr | output | 1 | Single-bit header error repaired |
| err_ecc_fatal | output | 1 | Uncorrectable header, packet dropped |
| link_reset_req | output | 1 | One-cycle request to the training logic |

## Verification
Every result is registered exactly once. Header fields, error flags, strobes, end-of-packet, CRC status and the reset request all appear in the cycle after the input cycle that caused them, and an idle cycle leaves its mark in that same later cycle. The bench changes inputs 1 ns after a rising edge. It samples all outputs 1 ns after the following rising edge, so each check lands on the single cycle in which a result is due. The bench works out the stream position of every lane itself, so it knows which cycle holds the CRC high byte. This covers the case where the CRC straddles two cycles and the final cycle carries no payload at all.

// File: rtl/slrx_pkg.sv
package slrx_pkg;

  localparam int unsigned HDR_BYTES = 4;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY  = 16'h8408;

  typedef enum logic {ST_IDLE, ST_BODY} rx_st_e;

  // Code position of header data bit j: j-th integer from 3 upward that is
  // not a power of two.
  function automatic logic [4:0] ecc_pos(input int unsigned j);
    int unsigned seen;
    logic [4:0]  r;
    seen = 0;
    r    = '0;
    for (int unsigned k = 3; k < 32; k++) begin
      if ((k & (k - 1)) != 0) begin
        if (seen == j) r = 5'(k);
        seen++;
      end
    end
    return r;
  endfunction

  // Six check bits over 24 header bits: five Hamming bits plus overall parity.
  function automatic logic [5:0] ecc_gen(input logic [23:0] d);
    logic [5:0] e;
    logic [4:0] p;
    e = '0;
    for (int unsigned j = 0; j < 24; j++) begin
      p = ecc_pos(j);
      for (int unsigned k = 0; k < 5; k++) begin
        if (p[k]) e[k] = e[k] ^ d[j];
      end
    end
    e[5] = (^d) ^ (^e[4:0]);
    return e;
  endfunction

  // One byte of the reflected CRC-16, LSB first.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = c ^ {8'h00, b};
    for (int unsigned i = 0; i < 8; i++) begin
      x = x[0] ? ((x >> 1) ^ CRC_POLY) : (x >> 1);
    end
    return x;
  endfunction

endpackage

// File: rtl/slrx_hdr_ecc.sv
module slrx_hdr_ecc
  import slrx_pkg::*;
(
  input  logic [23:0] data_i,
  input  logic [5:0]  ecc_i,
  output logic [23:0] data_o,
  output logic        corr_o,
  output logic        fatal_o
);

  logic [5:0] calc;
  logic [4:0] syn;
  logic       odd;
  logic       hit;

  always_comb begin
    calc    = ecc_gen(data_i);
    syn     = calc[4:0] ^ ecc_i[4:0];
    odd     = (^data_i) ^ (^ecc_i);
    data_o  = data_i;
    corr_o  = 1'b0;
    fatal_o = 1'b0;
    hit     = 1'b0;
    if (odd) begin
      if (syn == 5'd0 || $onehot(syn)) begin
        corr_o = 1'b1;                       // error sat in a check bit
      end else begin
        for (int unsigned j = 0; j < 24; j++) begin
          if (ecc_pos(j) == syn) begin
            data_o[j] = ~data_i[j];
            hit       = 1'b1;
          end
        end
        corr_o  = hit;
        fatal_o = !hit;
      end
    end else if (syn != 5'd0) begin
      fatal_o = 1'b1;                        // even count of flips: two bits
    end
  end

endmodule

// File: rtl/slrx_crc_chain.sv
module slrx_crc_chain
  import slrx_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [15:0]        seed_i,
  input  logic [LANES*8-1:0] data_i,
  input  logic [LANES-1:0]   use_i,
  output logic [15:0]        crc_o
);

  logic [15:0] stage [LANES+1];

  assign stage[0] = seed_i;

  for (genvar i = 0; i < LANES; i++) begin : g_step
    assign stage[i+1] = use_i[i] ? crc_step(stage[i], data_i[8*i +: 8]) : stage[i];
  end

  assign crc_o = stage[LANES];

endmodule

// File: rtl/slrx_err_policy.sv
module slrx_err_policy (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_fatal,
  input  logic ev_corr,
  input  logic ev_crc,
  input  logic en_fatal,
  input  logic en_corr,
  input  logic en_crc,
  output logic req_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= (ev_fatal && en_fatal) || (ev_corr && en_corr) || (ev_crc && en_crc);
  end

  // R11: a request needs at least one enable set in the cycle of its event
  a_r11_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_fatal && !en_corr && !en_crc) |=> !req_o);

endmodule

// File: rtl/slrx_packet_rx.sv
module slrx_packet_rx
  import slrx_pkg::*;
#(
  parameter int unsigned LANES        = 4,
  parameter logic [7:0]  SHORT_DI_MAX = 8'h0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [LANES*8-1:0] rx_data,
  input  logic               cfg_rst_on_fatal,
  input  logic               cfg_rst_on_corr,
  input  logic               cfg_rst_on_crc,
  output logic               hdr_valid,
  output logic [7:0]         hdr_di,
  output logic [15:0]        hdr_wc,
  output logic               hdr_long,
  output logic [LANES*8-1:0] pl_data,
  output logic [LANES-1:0]   pl_strb,
  output logic               pl_eop,
  output logic               pl_crc_err,
  output logic               err_ecc_corr,
  output logic               err_ecc_fatal,
  output logic               link_reset_req
);

  localparam int unsigned QW = 19;   // stream position width: 64 Ki + header + CRC

  rx_st_e         st_q;
  logic [QW-1:0]  q_q;               // stream position of lane 0 in the next body cycle
  logic [15:0]    wc_q;
  logic [15:0]    crc_q;
  logic [7:0]     crc_lo_q;

  // named events
  logic           hdr_cyc, body_cyc, start_long, active;
  logic           ev_hdr_ok, ev_corr, ev_fatal, ev_done, ev_crc_bad;
  logic [23:0]    hdr_fix;
  logic [7:0]     dec_di;
  logic [15:0]    dec_wc;
  logic           dec_corr, dec_fatal, dec_long;
  logic [15:0]    wc_eff;
  logic [QW-1:0]  q0, pl_end;
  logic [LANES-1:0] lane_pl, lane_lo, lane_hi;
  logic [7:0]     lo_now, hi_now, lo_byte;
  logic           any_lo;
  logic [15:0]    crc_seed, crc_new;

  assign hdr_cyc  = rx_valid && (st_q == ST_IDLE);
  assign body_cyc = rx_valid && (st_q == ST_BODY);

  slrx_hdr_ecc u_hdr (
    .data_i (rx_data[23:0]),
    .ecc_i  (rx_data[29:24]),
    .data_o (hdr_fix),
    .corr_o (dec_corr),
    .fatal_o(dec_fatal)
  );

  assign dec_di     = hdr_fix[7:0];
  assign dec_wc     = hdr_fix[23:8];
  assign dec_long   = dec_di > SHORT_DI_MAX;
  assign ev_hdr_ok  = hdr_cyc && !dec_fatal;
  assign ev_corr    = hdr_cyc && dec_corr;
  assign ev_fatal   = hdr_cyc && dec_fatal;
  assign start_long = ev_hdr_ok && dec_long;
  assign active     = start_long || body_cyc;

  assign wc_eff = hdr_cyc ? dec_wc : wc_q;
  assign q0     = hdr_cyc ? '0 : q_q;
  assign pl_end = {3'b000, wc_eff} + QW'(HDR_BYTES);

  // per-lane role from its stream position
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [QW-1:0] qi;
    assign qi         = q0 + QW'(i);
    assign lane_pl[i] = active && (qi >= QW'(HDR_BYTES)) && (qi < pl_end);
    assign lane_lo[i] = active && (qi == pl_end);
    assign lane_hi[i] = active && (qi == pl_end + QW'(1));
  end

  always_comb begin
    lo_now = '0;
    hi_now = '0;
    for (int unsigned i = 0; i < LANES; i++) begin
      if (lane_lo[i]) lo_now = lo_now | rx_data[8*i +: 8];
      if (lane_hi[i]) hi_now = hi_now | rx_data[8*i +: 8];
    end
  end

  assign any_lo   = |lane_lo;
  assign ev_done  = |lane_hi;
  assign lo_byte  = any_lo ? lo_now : crc_lo_q;
  assign crc_seed = hdr_cyc ? CRC_SEED : crc_q;

  slrx_crc_chain #(.LANES(LANES)) u_crc (
    .seed_i(crc_seed),
    .data_i(rx_data),
    .use_i (lane_pl),
    .crc_o (crc_new)
  );

  assign ev_crc_bad = ev_done && ({hi_now, lo_byte} != crc_new);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      q_q           <= '0;
      wc_q          <= '0;
      crc_q         <= CRC_SEED;
      crc_lo_q      <= '0;
      hdr_valid     <= 1'b0;
      hdr_di        <= '0;
      hdr_wc        <= '0;
      hdr_long      <= 1'b0;
      pl_data       <= '0;
      pl_strb       <= '0;
      pl_eop        <= 1'b0;
      pl_crc_err    <= 1'b0;
      err_ecc_corr  <= 1'b0;
      err_ecc_fatal <= 1'b0;
    end else begin
      hdr_valid     <= ev_hdr_ok;
      if (ev_hdr_ok) begin
        hdr_di   <= dec_di;
        hdr_wc   <= dec_wc;
        hdr_long <= dec_long;
      end
      err_ecc_corr  <= ev_corr;
      err_ecc_fatal <= ev_fatal;
      pl_data       <= rx_data;
      pl_strb       <= lane_pl;
      pl_eop        <= ev_done;
      pl_crc_err    <= ev_crc_bad;
      if (active) begin
        crc_q <= crc_new;
        if (any_lo) crc_lo_q <= lo_now;
      end
      if (start_long) begin
        wc_q <= dec_wc;
        q_q  <= QW'(LANES);
        if (!ev_done) st_q <= ST_BODY;
      end else if (body_cyc) begin
        q_q <= q_q + QW'(LANES);
        if (ev_done) st_q <= ST_IDLE;
      end
    end
  end

  slrx_err_policy u_pol (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_fatal(ev_fatal),
    .ev_corr (ev_corr),
    .ev_crc  (ev_crc_bad),
    .en_fatal(cfg_rst_on_fatal),
    .en_corr (cfg_rst_on_corr),
    .en_crc  (cfg_rst_on_crc),
    .req_o   (link_reset_req)
  );

  // R2: a header result needs a valid input cycle before it
  a_r2_hdr_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> $past(rx_valid));
  // R4: a repair is only reported with the accepted header
  a_r4_corr_with_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    err_ecc_corr |-> hdr_valid);
  // R5: a dropped header yields neither header nor payload
  a_r5_fatal_drops: assert property (@(posedge clk) disable iff (!rst_n)
    err_ecc_fatal |-> (!hdr_valid && pl_strb == '0 && !pl_eop));
  // R7: CRC status only travels with end of packet
  a_r7_crc_err_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
    pl_crc_err |-> pl_eop);
  // R9: an idle input cycle produces nothing
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (pl_strb == '0 && !hdr_valid && !pl_eop));
  // R10: a request always has an error event beside it
  a_r10_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    link_reset_req |-> (err_ecc_fatal || err_ecc_corr || pl_crc_err));

endmodule

// File: tb/slrx_packet_rx_tb.sv
`timescale 1ns/1ps
module slrx_packet_rx_tb;

  localparam int LANES = 4;
  localparam int DW    = LANES * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          cfg_f = 1'b0, cfg_c = 1'b0, cfg_r = 1'b0;
  logic          hdr_valid, hdr_long, pl_eop, pl_crc_err, err_ecc_corr, err_ecc_fatal, link_reset_req;
  logic [7:0]    hdr_di;
  logic [15:0]   hdr_wc;
  logic [DW-1:0] pl_data;
  logic [LANES-1:0] pl_strb;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  slrx_packet_rx #(.LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .cfg_rst_on_fatal(cfg_f), .cfg_rst_on_corr(cfg_c), .cfg_rst_on_crc(cfg_r),
    .hdr_valid(hdr_valid), .hdr_di(hdr_di), .hdr_wc(hdr_wc), .hdr_long(hdr_long),
    .pl_data(pl_data), .pl_strb(pl_strb), .pl_eop(pl_eop), .pl_crc_err(pl_crc_err),
    .err_ecc_corr(err_ecc_corr), .err_ecc_fatal(err_ecc_fatal), .link_reset_req(link_reset_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // syndrome-style code: XOR of positions of set bits, positions skip powers of two
  function automatic logic [5:0] tb_ecc(input logic [23:0] d);
    logic [5:0] p;
    int idx;
    p = '0;
    idx = 0;
    for (int pos = 1; pos < 32 && idx < 24; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[idx]) p[4:0] = p[4:0] ^ pos[4:0];
        idx++;
      end
    end
    p[5] = ^{d, p[4:0]};
    return p;
  endfunction

  function automatic logic [15:0] tb_crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic send_pkt(input string tag, input logic [7:0] di, input logic [15:0] wc,
                          input logic [23:0] dflip, input logic [7:0] eflip,
                          input bit bad_crc, input int stall_at, input bit idle_after);
    logic [7:0]       s [0:255];
    logic [15:0]      crc;
    logic [5:0]       ecc;
    logic [DW-1:0]    emask, edata;
    logic [LANES-1:0] estrb, padm;
    int  nflip, total, ncyc, eop_cyc, b;
    bit  corr, fatal, is_long, eeop, ereq;
    string etag;
    nflip   = $countones(dflip) + $countones(eflip[5:0]);
    corr    = (nflip == 1);
    fatal   = (nflip >= 2);
    is_long = (di > 8'h0F);
    ecc     = tb_ecc({wc, di});
    {s[2], s[1], s[0]} = {wc, di} ^ dflip;
    s[3]    = {2'b00, ecc} ^ eflip;
    total   = 4;
    crc     = 16'hFFFF;
    if (is_long) begin
      for (int k = 0; k < int'(wc); k++) begin
        s[4+k] = 8'(k * 37 + int'(di) + 3);
        crc    = tb_crc_byte(crc, s[4+k]);
      end
      if (bad_crc) crc = crc ^ 16'h0001;
      s[4+wc] = crc[7:0];
      s[5+wc] = crc[15:8];
      total   = 6 + int'(wc);
    end
    ncyc    = fatal ? 1 : (total + LANES - 1) / LANES;
    for (int k = total; k < ncyc * LANES; k++) s[k] = 8'hA5;
    eop_cyc = (is_long && !fatal) ? (total - 1) / LANES : -1;

    for (int c = 0; c < ncyc; c++) begin
      if (c == stall_at) begin
        rx_valid = 1'b0;
        rx_data  = {LANES{8'h5A}};
        @(posedge clk); #1;
        chk({tag, " R9 stall strobes"}, 64'(pl_strb), 64'(0));
        chk({tag, " R9 stall eop/hdr"}, 64'({pl_eop, hdr_valid}), 64'(0));
      end
      rx_valid = 1'b1;
      for (int l = 0; l < LANES; l++) rx_data[8*l +: 8] = s[c*LANES + l];
      @(posedge clk); #1;
      estrb = '0; emask = '0; edata = '0; padm = '0;
      for (int l = 0; l < LANES; l++) begin
        b = c * LANES + l;
        if (is_long && !fatal && b >= 4 && b < 4 + int'(wc)) begin
          estrb[l] = 1'b1;
          emask[8*l +: 8] = 8'hFF;
          edata[8*l +: 8] = s[b];
        end
        if (b >= total) padm[l] = 1'b1;
      end
      chk({tag, " R2 hdr_valid"}, 64'(hdr_valid), 64'(c == 0 && !fatal));
      if (c == 0 && !fatal) begin
        chk({tag, " R2 di"}, 64'(hdr_di), 64'(di));
        chk({tag, corr ? " R4 repaired wc" : " R2 wc"}, 64'(hdr_wc), 64'(wc));
        chk({tag, " R6 hdr_long"}, 64'(hdr_long), 64'(is_long));
      end
      chk({tag, corr ? " R4 corrected flag" : " R3 no corrected flag"}, 64'(err_ecc_corr), 64'(c == 0 && corr));
      chk({tag, fatal ? " R5 fatal flag" : " R3 no fatal flag"}, 64'(err_ecc_fatal), 64'(c == 0 && fatal));
      chk({tag, " R6 strobes"}, 64'(pl_strb), 64'(estrb));
      chk({tag, " R6 payload bytes"}, 64'(pl_data & emask), 64'(edata));
      if (c == ncyc - 1 && padm != '0)
        chk({tag, " R8 pad lanes unstrobed"}, 64'(pl_strb & padm), 64'(0));
      eeop = (c == eop_cyc);
      etag = !is_long ? " R12 no eop" : (wc == 16'd0 ? " R13 eop" : " R7 eop");
      chk({tag, etag}, 64'(pl_eop), 64'(eeop));
      chk({tag, " R7 crc error"}, 64'(pl_crc_err), 64'(eeop && bad_crc));
      ereq = (c == 0 && ((fatal && cfg_f) || (corr && cfg_c))) || (eeop && bad_crc && cfg_r);
      chk({tag, (cfg_f || cfg_c || cfg_r) ? " R10 reset request" : " R11 no reset request"},
          64'(link_reset_req), 64'(ereq));
    end
    rx_valid = 1'b0;
    rx_data  = '0;
    if (idle_after) begin
      @(posedge clk); #1;
      chk({tag, " R9 idle after packet"}, 64'({hdr_valid, pl_strb, pl_eop, link_reset_req}), 64'(0));
    end
  endtask

  task automatic set_cfg(input logic f, input logic c, input logic r);
    cfg_f = f; cfg_c = c; cfg_r = r;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset header outputs", 64'({hdr_valid, hdr_long, hdr_di, hdr_wc}), 64'(0));
    chk("R1 reset payload outputs", 64'({pl_data, pl_strb, pl_eop, pl_crc_err}), 64'(0));
    chk("R1 reset flags", 64'({err_ecc_corr, err_ecc_fatal, link_reset_req}), 64'(0));
    rst_n = 1'b1;
    @(posedge clk); #1;

    set_cfg(0, 0, 0);
    send_pkt("short",          8'h05, 16'h1234, 24'h0, 8'h00, 0, -1, 1);
    send_pkt("R12 b2b short",  8'h07, 16'h00AB, 24'h0, 8'h00, 0, -1, 0);
    send_pkt("R12 b2b long",   8'h2A, 16'd5,    24'h0, 8'h00, 0, -1, 1);
    send_pkt("crc straddle",   8'h31, 16'd7,    24'h0, 8'h00, 0, -1, 1);
    send_pkt("R13 empty long", 8'h22, 16'd0,    24'h0, 8'h00, 0, -1, 1);
    send_pkt("R9 stalled",     8'h40, 16'd12,   24'h0, 8'h00, 0,  2, 1);
    send_pkt("R3 high bits",   8'h33, 16'd6,    24'h0, 8'hC0, 0, -1, 1);

    set_cfg(0, 0, 1);
    send_pkt("crc bad",        8'h3C, 16'd9,    24'h0, 8'h00, 1, -1, 1);
    set_cfg(0, 0, 0);
    send_pkt("R11 crc bad",    8'h3C, 16'd10,   24'h0, 8'h00, 1, -1, 1);

    set_cfg(0, 1, 0);
    send_pkt("wc bit fix",     8'h2B, 16'd5,    24'h000200, 8'h00, 0, -1, 1);
    set_cfg(0, 0, 0);
    send_pkt("R11 ecc bit fix", 8'h2B, 16'd6,   24'h0, 8'h04, 0, -1, 1);
    send_pkt("di bit fix",     8'h05, 16'h0042, 24'h000001, 8'h00, 0, -1, 1);

    set_cfg(1, 0, 0);
    send_pkt("double error",   8'h2C, 16'd8,    24'h000003, 8'h00, 0, -1, 1);
    send_pkt("R5 recovery",    8'h2C, 16'd8,    24'h0, 8'h00, 0, -1, 1);
    set_cfg(0, 0, 0);
    send_pkt("R11 double",     8'h06, 16'h0100, 24'h010000, 8'h02, 0, -1, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual still running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule